// File: doc/BRIEF.md
# Out-of-Order Retiring Packet Ring Tracker

This block keeps the bookkeeping for a small on-chip ring of command packets. Three running indices describe the ring. The fill index marks the next slot to be filled. The issue index marks the next packet to hand to the execution side. The retire index marks the oldest packet that has not yet been released. Each index is a free-running counter, and the slot it points at is the counter modulo the ring depth. Each slot stores the type code of its packet and a done flag.

A fetch engine asks for space in blocks of N slots and writes a type code into each slot it fills. An issue engine steps the issue index while a valid packet waits. Execution units report that a packet has finished by giving its slot number, and they may report in any order. The tracker retires finished packets strictly in ring order, one slot per cycle. A retired slot returns to the invalid type.

Status outputs give the free slot count, whether a packet waits to be issued, how many issued packets are not yet retired, and whether the oldest unfinished packet is the only thing that holds back retirement.

Top module: `pkt_ring_tracker`

## Requirements
- R1: After reset all three indices are 0, the free count equals DEPTH, the in-flight count is 0, and `issue_ready`, `last_pending`, `grant_ok`, `grant_err` and `done_err` are all low.
- R2: A space request for N slots with N not above the free count moves the fill index forward by N. `grant_ok` pulses for one cycle after the clock edge that takes the request. The free count always equals DEPTH − (fill index − retire index).
- R3: A space request for N slots with N above the free count is refused. `grant_err` pulses for one cycle after the edge, and no index changes.
- R4: `issue_ready` is high only when the issue index is behind the fill index and the type stored at the issue slot is not the invalid code 0x01 (the default of INVALID_CODE). Every slot holds 0x01 after reset and again after it is retired.
- R5: `issue_step` while `issue_ready` is high moves the issue index forward by exactly 1. While `issue_ready` is low, `issue_step` is ignored.
- R6: The in-flight count always equals the issue index − the retire index.
- R7: A completion for a slot inside the in-flight window marks that slot done in the following cycle. Completions may arrive in any order. Starting one cycle after the slot at the retire index is marked done, the retire index moves forward by one slot per cycle over consecutive done slots and clears each slot's done flag.
- R8: A completion whose slot lies outside the window from the retire slot up to (not including) the issue slot is ignored. `done_err` pulses for one cycle, and no index and no done flag changes.
- R9: `last_pending` is high exactly when the retire index differs from the issue index, the packet at the retire slot is not done, and every packet between it and the issue index is done.
- R10: Slot numbers are the low bits of the indices (index modulo DEPTH, default 16). Behaviour is unchanged when the indices run past DEPTH and the slots wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_req | input | 1 | Request space for `grant_num` slots |
| grant_num | input | CNT_W | Number of slots requested |
| grant_ok | output | 1 | Request was granted (one-cycle pulse) |
| grant_err | output | 1 | Request was refused (one-cycle pulse) |
| fill_en | input | 1 | Write a type code into a slot |
| fill_slot | input | SLOT_W | Slot to write |
| fill_type | input | TYPE_W | Packet type code |
| issue_step | input | 1 | Advance the issue index |
| done_vld | input | 1 | Completion report |
| done_slot | input | SLOT_W | Slot of the completed packet |
| done_err | output | 1 | Completion outside the window (one-cycle pulse) |
| free_cnt | output | CNT_W | Free slots |
| issue_ready | output | 1 | A valid packet waits at the issue slot |
| inflight_cnt | output | CNT_W | Issued but not retired packets |
| last_pending | output | 1 | Only the oldest packet blocks retirement |
| fill_idx | output | IDX_W | Fill index |
| issue_idx | output | IDX_W | Issue index |
| retire_idx | output | IDX_W | Retire index |

## Verification
The assertions assume that the fetch engine writes type codes only into slots that are granted and not yet issued. They also assume that no completion is reported twice for one packet. The checks on ordering then hold because the retire index never passes the issue index, and the issue index never passes the fill index. The directed scenarios write types only into slots just granted. Each in-window slot is completed exactly once. Duplicate or stray reports appear only in the scenario that tests the out-of-window refusal.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;
   // ring geometry helpers shared by the tracker sub-blocks
   function automatic int slot_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ring_index_unit.sv
module ring_index_unit #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant_req,
   input  logic [CNT_W-1:0] grant_num,
   input  logic             issue_go,
   input  logic             retire_go,
   output logic [IDX_W-1:0] fill_idx,
   output logic [IDX_W-1:0] issue_idx,
   output logic [IDX_W-1:0] retire_idx,
   output logic [CNT_W-1:0] free_cnt,
   output logic [CNT_W-1:0] inflight_cnt,
   output logic             grant_ok,
   output logic             grant_err
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [IDX_W-1:0] used_w;
   logic [IDX_W-1:0] fly_w;
   logic             fits;

   always_comb begin
      used_w       = fill_idx - retire_idx;
      fly_w        = issue_idx - retire_idx;
      free_cnt     = DEPTH_C - used_w[CNT_W-1:0];
      inflight_cnt = fly_w[CNT_W-1:0];
      fits         = (grant_num <= free_cnt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_idx   <= '0;
         issue_idx  <= '0;
         retire_idx <= '0;
         grant_ok   <= 1'b0;
         grant_err  <= 1'b0;
      end else begin
         grant_ok  <= grant_req && fits;
         grant_err <= grant_req && !fits;
         if (grant_req && fits)
            fill_idx <= fill_idx + IDX_W'(grant_num);
         if (issue_go)
            issue_idx <= issue_idx + 1'b1;
         if (retire_go)
            retire_idx <= retire_idx + 1'b1;
      end
   end

   assert_free_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= DEPTH_C);
   assert_refuse_keeps_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_err |-> (fill_idx == $past(fill_idx)));
   assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idx - retire_idx) <= (fill_idx - retire_idx));
   assert_ok_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_ok && grant_err));
endmodule

// File: rtl/ring_type_store.sv
module ring_type_store #(
   parameter int DEPTH  = 16,
   parameter int SLOT_W = 4,
   parameter int TYPE_W = 8,
   parameter logic [TYPE_W-1:0] INVALID_CODE = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [TYPE_W-1:0] fill_type,
   input  logic              clr_en,
   input  logic [SLOT_W-1:0] clr_slot,
   input  logic [SLOT_W-1:0] issue_slot,
   output logic              issue_type_ok
);
   logic [TYPE_W-1:0] type_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            type_q[s] <= INVALID_CODE;
         else if (fill_en && fill_slot == SLOT_W'(s))
            type_q[s] <= fill_type;
         else if (clr_en && clr_slot == SLOT_W'(s))
            type_q[s] <= INVALID_CODE;
      end
   end

   assign issue_type_ok = (type_q[issue_slot] != INVALID_CODE);

   assert_clear_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(fill_en && fill_slot == clr_slot)) |=> (type_q[$past(clr_slot)] == INVALID_CODE));
endmodule

// File: rtl/ring_done_tracker.sv
module ring_done_tracker #(
   parameter int DEPTH  = 16,
   parameter int SLOT_W = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] retire_slot,
   input  logic [CNT_W-1:0]  inflight_cnt,
   input  logic              done_vld,
   input  logic [SLOT_W-1:0] done_slot,
   output logic              retire_go,
   output logic              done_err,
   output logic              last_pending
);
   logic [DEPTH-1:0]  done_q;
   logic [SLOT_W-1:0] rel_off;
   logic              in_win;
   logic              hit;
   logic              rest_done;

   always_comb begin
      rel_off   = done_slot - retire_slot;
      in_win    = ({1'b0, rel_off} < inflight_cnt);
      hit       = done_vld && in_win;
      retire_go = (inflight_cnt != '0) && done_q[retire_slot];
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_done
      always_ff @(posedge clk) begin
         if (!rst_n)
            done_q[s] <= 1'b0;
         else if (retire_go && retire_slot == SLOT_W'(s))
            done_q[s] <= 1'b0;
         else if (hit && done_slot == SLOT_W'(s))
            done_q[s] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done_err <= 1'b0;
      else        done_err <= done_vld && !in_win;
   end

   // every younger in-flight slot must already be done
   always_comb begin
      rest_done = 1'b1;
      for (int k = 1; k < DEPTH; k++) begin
         if ((CNT_W'(k) < inflight_cnt) && !done_q[retire_slot + SLOT_W'(k)])
            rest_done = 1'b0;
      end
      last_pending = (inflight_cnt != '0) && !done_q[retire_slot] && rest_done;
   end

   assert_err_from_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> $past(done_vld));
   assert_err_no_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && !in_win && !retire_go) |=> (done_q == $past(done_q)));
   assert_retire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      retire_go |=> !done_q[$past(retire_slot)]);
endmodule

// File: rtl/pkt_ring_tracker.sv
module pkt_ring_tracker
   import pkt_ring_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 16,
   parameter int TYPE_W = 8,
   parameter logic [TYPE_W-1:0] INVALID_CODE = 8'h01,
   localparam int SLOT_W = slot_bits(DEPTH),
   localparam int CNT_W  = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_req,
   input  logic [CNT_W-1:0]  grant_num,
   output logic              grant_ok,
   output logic              grant_err,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [TYPE_W-1:0] fill_type,
   input  logic              issue_step,
   input  logic              done_vld,
   input  logic [SLOT_W-1:0] done_slot,
   output logic              done_err,
   output logic [CNT_W-1:0]  free_cnt,
   output logic              issue_ready,
   output logic [CNT_W-1:0]  inflight_cnt,
   output logic              last_pending,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [IDX_W-1:0]  issue_idx,
   output logic [IDX_W-1:0]  retire_idx
);
   initial begin
      assert (is_pow2(DEPTH) && DEPTH >= 2)
         else $error("DEPTH must be a power of two, at least 2");
      assert (IDX_W > SLOT_W)
         else $error("IDX_W must exceed the slot width");
      assert (TYPE_W >= 1)
         else $error("TYPE_W must be positive");
   end

   logic issue_type_ok;
   logic issue_go;
   logic retire_go;
   logic [SLOT_W-1:0] issue_slot;
   logic [SLOT_W-1:0] retire_slot;

   assign issue_slot  = issue_idx[SLOT_W-1:0];
   assign retire_slot = retire_idx[SLOT_W-1:0];
   assign issue_ready = (issue_idx != fill_idx) && issue_type_ok;
   assign issue_go    = issue_step && issue_ready;

   ring_index_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_idx (
      .clk(clk), .rst_n(rst_n),
      .grant_req(grant_req), .grant_num(grant_num),
      .issue_go(issue_go), .retire_go(retire_go),
      .fill_idx(fill_idx), .issue_idx(issue_idx), .retire_idx(retire_idx),
      .free_cnt(free_cnt), .inflight_cnt(inflight_cnt),
      .grant_ok(grant_ok), .grant_err(grant_err)
   );

   ring_type_store #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .TYPE_W(TYPE_W),
                     .INVALID_CODE(INVALID_CODE)) u_type (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_slot(fill_slot), .fill_type(fill_type),
      .clr_en(retire_go), .clr_slot(retire_slot),
      .issue_slot(issue_slot), .issue_type_ok(issue_type_ok)
   );

   ring_done_tracker #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_done (
      .clk(clk), .rst_n(rst_n),
      .retire_slot(retire_slot), .inflight_cnt(inflight_cnt),
      .done_vld(done_vld), .done_slot(done_slot),
      .retire_go(retire_go), .done_err(done_err), .last_pending(last_pending)
   );

   assert_issue_moves_only_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idx != $past(issue_idx)) |-> $past(issue_step && issue_ready));
   assert_retire_needs_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_idx != $past(retire_idx)) |-> ($past(inflight_cnt) != '0));
   assert_last_has_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
      last_pending |-> (issue_idx != retire_idx));
   assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_idx - $past(issue_idx)) <= IDX_W'(1));
endmodule

// File: tb/sim_pkt_ring_tracker.sv
module sim_pkt_ring_tracker;
   localparam int DEPTH = 16;
   localparam int IDX_W = 16;
   localparam int TYPE_W = 8;
   localparam int SLOT_W = 4;
   localparam int CNT_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant_req = 1'b0;
   logic [CNT_W-1:0] grant_num = '0;
   logic grant_ok, grant_err;
   logic fill_en = 1'b0;
   logic [SLOT_W-1:0] fill_slot = '0;
   logic [TYPE_W-1:0] fill_type = '0;
   logic issue_step = 1'b0;
   logic done_vld = 1'b0;
   logic [SLOT_W-1:0] done_slot = '0;
   logic done_err;
   logic [CNT_W-1:0] free_cnt, inflight_cnt;
   logic issue_ready, last_pending;
   logic [IDX_W-1:0] fill_idx, issue_idx, retire_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pkt_ring_tracker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .TYPE_W(TYPE_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .grant_req(grant_req), .grant_num(grant_num),
      .grant_ok(grant_ok), .grant_err(grant_err),
      .fill_en(fill_en), .fill_slot(fill_slot), .fill_type(fill_type),
      .issue_step(issue_step), .done_vld(done_vld), .done_slot(done_slot),
      .done_err(done_err), .free_cnt(free_cnt), .issue_ready(issue_ready),
      .inflight_cnt(inflight_cnt), .last_pending(last_pending),
      .fill_idx(fill_idx), .issue_idx(issue_idx), .retire_idx(retire_idx)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_grant(input int n);
      grant_req = 1'b1; grant_num = CNT_W'(n);
      @(negedge clk);
      grant_req = 1'b0;
   endtask

   task automatic do_fill(input int slot, input int t);
      fill_en = 1'b1; fill_slot = SLOT_W'(slot); fill_type = TYPE_W'(t);
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic do_issue();
      issue_step = 1'b1;
      @(negedge clk);
      issue_step = 1'b0;
   endtask

   task automatic do_done(input int slot);
      done_vld = 1'b1; done_slot = SLOT_W'(slot);
      @(negedge clk);
      done_vld = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 fill", int'(fill_idx), 0);
      chk("R1 issue", int'(issue_idx), 0);
      chk("R1 retire", int'(retire_idx), 0);
      chk("R1 free", int'(free_cnt), DEPTH);
      chk("R1 inflight", int'(inflight_cnt), 0);
      chk("R1 flags", int'({issue_ready, last_pending, grant_ok, grant_err, done_err}), 0);
   endtask

   task automatic t_grant();
      do_grant(4);
      chk("R2 ok", int'(grant_ok), 1);
      chk("R2 fill", int'(fill_idx), 4);
      chk("R2 free", int'(free_cnt), 12);
      do_grant(13);
      chk("R3 err", int'(grant_err), 1);
      chk("R3 fill kept", int'(fill_idx), 4);
      chk("R3 free kept", int'(free_cnt), 12);
      @(negedge clk);
      chk("R3 err pulse", int'(grant_err), 0);
   endtask

   task automatic t_issue();
      chk("R4 invalid slot", int'(issue_ready), 0);
      do_issue();
      chk("R5 ignored", int'(issue_idx), 0);
      for (int s = 0; s < 4; s++) do_fill(s, 8'h10 + s);
      chk("R4 ready", int'(issue_ready), 1);
      for (int s = 0; s < 4; s++) do_issue();
      chk("R5 issue", int'(issue_idx), 4);
      chk("R6 inflight", int'(inflight_cnt), 4);
      chk("R4 caught up", int'(issue_ready), 0);
      do_issue();
      chk("R5 ignored at fill", int'(issue_idx), 4);
   endtask

   task automatic t_ooo();
      do_done(5);
      chk("R8 err", int'(done_err), 1);
      chk("R8 retire kept", int'(retire_idx), 0);
      chk("R8 inflight kept", int'(inflight_cnt), 4);
      do_done(2);
      do_done(3);
      chk("R9 gap", int'(last_pending), 0);
      chk("R7 no retire", int'(retire_idx), 0);
      do_done(1);
      chk("R9 last", int'(last_pending), 1);
      chk("R8 no err", int'(done_err), 0);
      do_done(0);
      chk("R7 marked", int'(retire_idx), 0);
      chk("R9 cleared", int'(last_pending), 0);
      @(negedge clk);
      chk("R7 step1", int'(retire_idx), 1);
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R7 drained", int'(retire_idx), 4);
      chk("R6 zero", int'(inflight_cnt), 0);
      chk("R2 free back", int'(free_cnt), DEPTH);
      @(negedge clk);
      chk("R7 stops", int'(retire_idx), 4);
   endtask

   task automatic t_wrap();
      do_grant(16);
      chk("R10 fill", int'(fill_idx), 20);
      chk("R2 full", int'(free_cnt), 0);
      do_grant(1);
      chk("R3 full err", int'(grant_err), 1);
      for (int s = 4; s < 16; s++) do_fill(s, 8'h22);
      for (int s = 4; s < 16; s++) do_issue();
      chk("R10 issue", int'(issue_idx), 16);
      chk("R4 retired slot invalid", int'(issue_ready), 0);
      for (int s = 0; s < 4; s++) do_fill(s, 8'h33);
      chk("R4 refilled", int'(issue_ready), 1);
      for (int s = 0; s < 4; s++) do_issue();
      chk("R10 issue end", int'(issue_idx), 20);
      chk("R6 all fly", int'(inflight_cnt), 16);
      for (int i = 19; i > 4; i--) do_done(i % DEPTH);
      chk("R10 last", int'(last_pending), 1);
      do_done(4);
      for (int i = 0; i < 17; i++) @(negedge clk);
      chk("R10 retire", int'(retire_idx), 20);
      chk("R10 free", int'(free_cnt), DEPTH);
      chk("R9 idle", int'(last_pending), 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_grant();
            t_issue();
            t_ooo();
            t_wrap();
         end
         begin
            repeat (5000) @(negedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule